// File: doc/BRIEF.md
# Saturating-Counter Branch Direction Predictor

This block guesses the direction of conditional branches at fetch time. A direct-mapped, tagged table holds one saturating counter of configurable width per tracked branch. A fetch unit presents an instruction address on the lookup port, together with a flag saying whether the word is a branch and the branch's target offset. One cycle later the block returns a taken or not-taken guess and the address fetch should go to next. That predicted address travels with the instruction so a later commit stage can compare it with the resolved one.

When the fetch side cannot trust a guess, the block raises a stall instead of a prediction. This happens for a branch flagged as unpredictable, or for any lookup with a forced stall. Fetch then holds until older work completes and takes the resolved PC from elsewhere. At resolution time the update port trains the counter for the branch's address. It allocates an entry when none matches, and otherwise steps the counter toward the observed outcome.

Top module: `bdir_predictor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all prediction outputs are zero and every table entry is empty, so all branches miss.
- R2: The outputs in any cycle are fully determined by the lookup inputs sampled at the previous rising clock edge and the table contents before that edge. They are registered and are not held past one cycle.
- R3: A predictable branch lookup whose entry is empty or holds a different tag gives pred_valid=1, pred_taken=0 and pred_addr = lookup address + 4.
- R4: A predictable branch lookup that hits an entry whose counter is at least 2^(N-1) (counter MSB set) gives pred_taken=1 and pred_addr = lookup address + target offset. A hit with a lower counter behaves as in R3.
- R5: An update with outcome taken that hits an entry increments its counter, saturating at 2^N-1.
- R6: An update with outcome not taken that hits an entry decrements its counter, saturating at 0.
- R7: An update that misses writes the entry at its index with the new tag, and sets the counter to 2^(N-1) if taken or 2^(N-1)-1 if not taken.
- R8: Address bits [IDX_W+1:2] select the entry and bits [ADDR_W-1:IDX_W+2] form the tag; bits [1:0] are ignored. Two addresses that share an index but differ in tag evict each other.
- R9: A lookup with the forced-stall input set, or a branch lookup with the unpredictable flag set, gives pred_stall=1 with pred_valid, pred_taken and pred_addr all zero.
- R10: A lookup of a non-branch word without a stall gives pred_valid=0, pred_stall=0, pred_taken=0 and pred_addr = address + 4. A cycle with no lookup gives all outputs zero.
- R11: When a lookup and an update to the same entry share a cycle, the lookup sees the entry as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | ADDR_W | Address of the fetched word |
| lk_is_branch | input | 1 | The word is a conditional branch |
| lk_no_predict | input | 1 | The branch must wait for resolution |
| lk_force_stall | input | 1 | Stall regardless of instruction kind |
| lk_target | input | ADDR_W | Offset added to the address when taken |
| upd_valid | input | 1 | A resolved branch trains the table |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| pred_valid | output | 1 | A direction guess is present |
| pred_taken | output | 1 | The guess is taken |
| pred_stall | output | 1 | Fetch must wait for resolution |
| pred_addr | output | ADDR_W | Predicted next fetch address |

## Verification
Every output is due exactly one rising edge after the lookup that caused it. A table update takes effect at that same edge, so it first shows in a lookup presented on the following cycle. The bench drives inputs on the falling edge and computes the expected outputs from its model as it stood before applying that cycle's update. It then compares all four outputs on the next falling edge, once per cycle. Directed sequences cover allocation, both saturation limits, eviction, stalls and same-cycle lookup and update, and a random phase over a few aliasing addresses follows them.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    // Classification of one lookup request
    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_STALL  = 2'd1,
        LK_PLAIN  = 2'd2,
        LK_BRANCH = 2'd3
    } lk_kind_e;

endpackage

// File: rtl/bdp_sat_ctr.sv
module bdp_sat_ctr #(
    parameter int CTR_W = 2
) (
    input  logic             hit,
    input  logic             taken,
    input  logic [CTR_W-1:0] cur,
    output logic [CTR_W-1:0] nxt
);
    localparam logic [CTR_W-1:0] MAXV   = '1;
    localparam logic [CTR_W-1:0] ONE    = CTR_W'(1);
    localparam logic [CTR_W-1:0] HALF   = ONE << (CTR_W - 1);
    localparam logic [CTR_W-1:0] HALF_M = HALF - ONE;

    always_comb begin
        if (!hit) begin
            nxt = taken ? HALF : HALF_M;
        end else if (taken) begin
            nxt = (cur == MAXV) ? cur : cur + ONE;
        end else begin
            nxt = (cur == '0) ? cur : cur - ONE;
        end
    end
endmodule

// File: rtl/bdp_table.sv
module bdp_table #(
    parameter int ADDR_W  = 32,
    parameter int CTR_W   = 2,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [CTR_W-1:0]  rd_ctr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_taken
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CTR_W-1:0] ctr;
    } ent_t;

    ent_t ent_view [ENTRIES];

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [IDX_W-1:0] rd_idx;
    logic [TAG_W-1:0] rd_tag;

    assign wr_idx = wr_addr[IDX_W+1:2];
    assign wr_tag = wr_addr[ADDR_W-1:IDX_W+2];
    assign rd_idx = rd_addr[IDX_W+1:2];
    assign rd_tag = rd_addr[ADDR_W-1:IDX_W+2];

    for (genvar g = 0; g < ENTRIES; g++) begin : gen_ent
        ent_t             ent_d;
        ent_t             ent_q;
        logic             wr_hit;
        logic [CTR_W-1:0] ctr_nxt;

        assign wr_hit = ent_q.vld && (ent_q.tag == wr_tag);

        bdp_sat_ctr #(.CTR_W(CTR_W)) u_ctr (
            .hit   (wr_hit),
            .taken (wr_taken),
            .cur   (ent_q.ctr),
            .nxt   (ctr_nxt)
        );

        always_comb begin
            ent_d = ent_q;
            if (wr_valid && (wr_idx == IDX_W'(g))) begin
                ent_d.vld = 1'b1;
                ent_d.tag = wr_tag;
                ent_d.ctr = ctr_nxt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_view[g] = ent_q;
    end

    always_comb begin
        rd_hit = ent_view[rd_idx].vld && (ent_view[rd_idx].tag == rd_tag);
        rd_ctr = ent_view[rd_idx].ctr;
    end
endmodule

// File: rtl/bdp_decide.sv
module bdp_decide
    import bdp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTR_W  = 2
) (
    input  logic              lk_valid,
    input  logic              lk_is_branch,
    input  logic              lk_no_predict,
    input  logic              lk_force_stall,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ADDR_W-1:0] lk_target,
    input  logic              hit,
    input  logic [CTR_W-1:0]  ctr,
    output logic              nxt_valid,
    output logic              nxt_taken,
    output logic              nxt_stall,
    output logic [ADDR_W-1:0] nxt_addr
);
    lk_kind_e          kind;
    logic              guess;
    logic [ADDR_W-1:0] fall_addr;

    assign fall_addr = lk_addr + ADDR_W'(4);
    // At or above half of the state count is exactly "MSB set"
    assign guess     = hit && ctr[CTR_W-1];

    always_comb begin
        if (!lk_valid) begin
            kind = LK_IDLE;
        end else if (lk_force_stall || (lk_is_branch && lk_no_predict)) begin
            kind = LK_STALL;
        end else if (lk_is_branch) begin
            kind = LK_BRANCH;
        end else begin
            kind = LK_PLAIN;
        end
    end

    always_comb begin
        nxt_valid = 1'b0;
        nxt_taken = 1'b0;
        nxt_stall = 1'b0;
        nxt_addr  = '0;
        unique case (kind)
            LK_IDLE:  ;
            LK_STALL: nxt_stall = 1'b1;
            LK_PLAIN: nxt_addr  = fall_addr;
            LK_BRANCH: begin
                nxt_valid = 1'b1;
                nxt_taken = guess;
                nxt_addr  = guess ? (lk_addr + lk_target) : fall_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor #(
    parameter int ADDR_W  = 32,
    parameter int CTR_W   = 2,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_is_branch,
    input  logic              lk_no_predict,
    input  logic              lk_force_stall,
    input  logic [ADDR_W-1:0] lk_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic              pred_stall,
    output logic [ADDR_W-1:0] pred_addr
);
    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              stall;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t             out_d;
    out_t             out_q;
    logic             tbl_hit;
    logic [CTR_W-1:0] tbl_ctr;

    bdp_table #(
        .ADDR_W  (ADDR_W),
        .CTR_W   (CTR_W),
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (lk_addr),
        .rd_hit   (tbl_hit),
        .rd_ctr   (tbl_ctr),
        .wr_valid (upd_valid),
        .wr_addr  (upd_addr),
        .wr_taken (upd_taken)
    );

    bdp_decide #(
        .ADDR_W (ADDR_W),
        .CTR_W  (CTR_W)
    ) u_decide (
        .lk_valid       (lk_valid),
        .lk_is_branch   (lk_is_branch),
        .lk_no_predict  (lk_no_predict),
        .lk_force_stall (lk_force_stall),
        .lk_addr        (lk_addr),
        .lk_target      (lk_target),
        .hit            (tbl_hit),
        .ctr            (tbl_ctr),
        .nxt_valid      (out_d.valid),
        .nxt_taken      (out_d.taken),
        .nxt_stall      (out_d.stall),
        .nxt_addr       (out_d.addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pred_valid = out_q.valid;
    assign pred_taken = out_q.taken;
    assign pred_stall = out_q.stall;
    assign pred_addr  = out_q.addr;
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_is_branch,
    input logic              lk_no_predict,
    input logic              lk_force_stall,
    input logic [ADDR_W-1:0] lk_target,
    input logic              pred_valid,
    input logic              pred_taken,
    input logic              pred_stall,
    input logic [ADDR_W-1:0] pred_addr
);
    // R9
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_stall && (pred_valid || pred_taken)));

    // R9
    force_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_force_stall) |=> pred_stall);

    // R2
    pred_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_is_branch && !lk_no_predict && !lk_force_stall) |=> pred_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pred_valid && !pred_stall && !pred_taken && pred_addr == '0));

    // R3
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_force_stall && !(lk_is_branch && lk_no_predict))
        |=> (pred_taken || pred_addr == $past(lk_addr) + ADDR_W'(4)));

    // R4
    taken_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> (pred_valid && pred_addr == $past(lk_addr) + $past(lk_target)));
endmodule

bind bdir_predictor bdp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_addr        (lk_addr),
    .lk_is_branch   (lk_is_branch),
    .lk_no_predict  (lk_no_predict),
    .lk_force_stall (lk_force_stall),
    .lk_target      (lk_target),
    .pred_valid     (pred_valid),
    .pred_taken     (pred_taken),
    .pred_stall     (pred_stall),
    .pred_addr      (pred_addr)
);

// File: tb/bdir_predictor_tb.sv
module bdir_predictor_tb;
    localparam int CW   = 2;
    localparam int NENT = 16;
    localparam int CMAX = (1 << CW) - 1;
    localparam int HALF = 1 << (CW - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_is_branch = 1'b0;
    logic        lk_no_predict = 1'b0;
    logic        lk_force_stall = 1'b0;
    logic [31:0] lk_target = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic        pred_valid;
    logic        pred_taken;
    logic        pred_stall;
    logic [31:0] pred_addr;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Behavioural model of the table
    bit          m_vld [NENT];
    int unsigned m_tag [NENT];
    int          m_ctr [NENT];

    bit          e_valid, e_taken, e_stall;
    logic [31:0] e_addr;

    always #5 clk = ~clk;

    bdir_predictor #(.ADDR_W(32), .CTR_W(CW), .ENTRIES(NENT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_is_branch(lk_is_branch),
        .lk_no_predict(lk_no_predict), .lk_force_stall(lk_force_stall),
        .lk_target(lk_target),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .pred_stall(pred_stall), .pred_addr(pred_addr)
    );

    task automatic compare(input string req);
        vectors++;
        if (pred_valid !== e_valid || pred_taken !== e_taken ||
            pred_stall !== e_stall || pred_addr !== e_addr) begin
            miscompares++;
            $display("FAIL %s: got v=%0b t=%0b s=%0b a=%h, expected v=%0b t=%0b s=%0b a=%h",
                     req, pred_valid, pred_taken, pred_stall, pred_addr,
                     e_valid, e_taken, e_stall, e_addr);
        end
    endtask

    // Called at a falling edge: drive, predict, train model, wait, compare
    task automatic step(input bit v, input bit br, input bit np, input bit fs,
                        input logic [31:0] a, input logic [31:0] t,
                        input bit uv, input logic [31:0] ua, input bit ut,
                        input string req);
        int idx;
        bit hit;
        lk_valid = v; lk_is_branch = br; lk_no_predict = np; lk_force_stall = fs;
        lk_addr = a; lk_target = t;
        upd_valid = uv; upd_addr = ua; upd_taken = ut;
        e_valid = 0; e_taken = 0; e_stall = 0; e_addr = '0;
        if (v) begin
            if (fs || (br && np)) begin
                e_stall = 1;
            end else if (!br) begin
                e_addr = a + 32'd4;
            end else begin
                idx = int'(a[5:2]);
                hit = m_vld[idx] && (m_tag[idx] == int'(a[31:6]));
                e_valid = 1;
                e_taken = hit && (m_ctr[idx] >= HALF);
                e_addr  = e_taken ? a + t : a + 32'd4;
            end
        end
        if (uv) begin
            idx = int'(ua[5:2]);
            hit = m_vld[idx] && (m_tag[idx] == int'(ua[31:6]));
            if (!hit) begin
                m_vld[idx] = 1;
                m_tag[idx] = int'(ua[31:6]);
                m_ctr[idx] = ut ? HALF : HALF - 1;
            end else if (ut) begin
                if (m_ctr[idx] < CMAX) m_ctr[idx]++;
            end else begin
                if (m_ctr[idx] > 0) m_ctr[idx]--;
            end
        end
        @(negedge clk);
        compare(req);
    endtask

    task automatic look(input logic [31:0] a, input logic [31:0] t, input string req);
        step(1, 1, 0, 0, a, t, 0, '0, 0, req);
    endtask

    task automatic train(input logic [31:0] a, input bit tk, input string req);
        step(0, 0, 0, 0, '0, '0, 1, a, tk, req);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_vld[i] = 0; m_tag[i] = 0; m_ctr[i] = 0;
        end
        // R1: outputs zero during reset
        e_valid = 0; e_taken = 0; e_stall = 0; e_addr = '0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        // R1: empty table -> miss
        look(32'h0000_0100, 32'h40, "R1");
        // R3: miss predicts fall-through
        look(32'h0000_0204, 32'h80, "R3");
        // R10: idle and non-branch
        step(0, 0, 0, 0, 32'h0000_0300, '0, 0, '0, 0, "R10");
        step(1, 0, 0, 0, 32'h0000_0300, 32'h20, 0, '0, 0, "R10");
        // R7: allocate taken -> half, predicts taken
        train(32'h0000_0100, 1, "R7");
        look(32'h0000_0100, 32'h40, "R4");
        // R7: allocate not-taken -> half-1, not taken
        train(32'h0000_0204, 0, "R7");
        look(32'h0000_0204, 32'h80, "R7");
        // R5: saturate high, one decrement still taken
        for (int i = 0; i < 5; i++) train(32'h0000_0100, 1, "R5");
        train(32'h0000_0100, 0, "R5");
        look(32'h0000_0100, 32'h40, "R5");
        train(32'h0000_0100, 0, "R5");
        look(32'h0000_0100, 32'h40, "R5");
        // R6: saturate low, one increment still not taken
        for (int i = 0; i < 5; i++) train(32'h0000_0204, 0, "R6");
        train(32'h0000_0204, 1, "R6");
        look(32'h0000_0204, 32'h80, "R6");
        train(32'h0000_0204, 1, "R6");
        look(32'h0000_0204, 32'hFFFF_FFF0, "R6");
        // R8: low bits ignored, alias misses, eviction
        train(32'h0000_0100, 1, "R8");
        train(32'h0000_0100, 1, "R8");
        look(32'h0000_0103, 32'h10, "R8");
        look(32'h0000_0140, 32'h10, "R8");
        train(32'h0000_0140, 1, "R8");
        look(32'h0000_0140, 32'h10, "R8");
        look(32'h0000_0100, 32'h40, "R8");
        // R11: same-cycle lookup and update
        step(1, 1, 0, 0, 32'h0000_0388, 32'h8, 1, 32'h0000_0388, 1, "R11");
        look(32'h0000_0388, 32'h8, "R11");
        // R9: stalls leave table alone
        step(1, 1, 1, 0, 32'h0000_0388, 32'h8, 0, '0, 0, "R9");
        step(1, 0, 0, 1, 32'h0000_0400, 32'h8, 0, '0, 0, "R9");
        step(1, 1, 0, 1, 32'h0000_0388, 32'h8, 0, '0, 0, "R9");
        look(32'h0000_0388, 32'h8, "R9");
        // R2: random mix checked every cycle
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, ua, t;
            a  = 32'h1000 + 32'($urandom_range(0, 2) * 64 + $urandom_range(0, 7) * 4);
            ua = 32'h1000 + 32'($urandom_range(0, 2) * 64 + $urandom_range(0, 7) * 4);
            t  = 32'($urandom_range(0, 255)) << 2;
            step(($urandom % 8) != 0, ($urandom % 5) != 0, ($urandom % 10) == 0,
                 ($urandom % 12) == 0, a, t, ($urandom % 2) == 0, ua,
                 ($urandom % 3) != 0, "R2");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule